// File: doc/BRIEF.md
# Dual-Comparator Gray Code Corrector

This block sits behind a flash quantizer whose comparators have a periodic transfer curve, so each one reports one bit of a Gray code. Every bit position below the MSB is watched by two comparators, a leading one and a lagging one, with thresholds one LSB apart. That spacing is a quarter of the period of the least significant comparator. Near any input level at most one comparator of a pair sits close to its threshold, so the block can always pick a trustworthy decision.

The corrector works from the MSB down. For each lower bit it uses the binary bit already decided one place higher to choose between the leading and the lagging comparator. It then folds the chosen Gray bit into the running XOR, so the same chain that resolves the comparator pairs also converts Gray code to binary. A second, interleaved comparator pair set half a step apart adds one finer bit below the LSB through an XOR. The result is registered through a two-stage pipeline that accepts one sample per clock.

Top module: `gray_lookback_corrector`

## Requirements
- R1: While rst_ni is low and until the first result arrives, valid_o is 0 and code_o is all zeros.
- R2: A sample presented with valid_i high produces valid_o high exactly two clock cycles later. A cycle with valid_i low produces valid_o low two cycles later.
- R3: While valid_o is low, code_o keeps its previous value whatever the inputs do.
- R4: When lead_i[N_BITS-2:0] equals lag_i, the upper N_BITS bits of code_o are the binary value of the Gray code on lead_i. Binary bit k is the XOR of Gray bits k through N_BITS-1.
- R5: The MSB of code_o always equals lead_i[N_BITS-1] of the same sample.
- R6: For bit k below the MSB, the Gray bit is taken from lead_i[k] when the already-decided binary bit k+1 is 0, and from lag_i[k] when it is 1. Binary bit k is binary bit k+1 XOR that chosen bit. Consequence for adjacent codes: let j be the number of trailing ones of u. With lead = Gray(u+1) and lag = Gray(u), the output is u when bit j+1 of u is 1, otherwise u+1. With lead = Gray(u) and lag = Gray(u+1), the output is u+1 when bit j+1 of u is 1, otherwise u.
- R7: With EXTRA_LSB = 1, code_o[0] is ilv_a_i XOR ilv_b_i of the same sample.
- R8: When lead and lag are the Gray codes of two adjacent levels, including after a random disagreement on the comparator nearest its threshold, the upper field of the output stays within one LSB of the true level. Over an error-free rising sweep it never decreases.
- R9: Samples presented on consecutive cycles each yield their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Comparator decisions on this cycle are a sample |
| lead_i | input | N_BITS | Leading comparator decision per bit; bit N_BITS-1 is the MSB |
| lag_i | input | N_BITS-1 | Lagging comparator decision for bits N_BITS-2..0 |
| ilv_a_i | input | 1 | First comparator of the interleaved pair |
| ilv_b_i | input | 1 | Second comparator of the interleaved pair |
| code_o | output | N_BITS+EXTRA_LSB | Corrected binary code; the finer bit, if present, is bit 0 |
| valid_o | output | 1 | code_o carries a new result |

## Verification
The hardest case to reach is a pair that disagrees in exactly the bit whose threshold lies between the two comparators, with the deciding upper bit in each of its two states. Random comparator patterns almost never form two neighbouring Gray codes. The stimulus therefore builds pairs from adjacent levels in both orders for every level. It also runs a fine-grained sweep in quarter-LSB steps in which both comparators track one model input. On top of that sweep, the bench randomly copies one comparator's decision onto its partner at the bit nearest its threshold.

// File: rtl/gec_pkg.sv
package gec_pkg;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/gec_stage.sv
module gec_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

endmodule

// File: rtl/gec_resolve.sv
module gec_resolve #(
  parameter int N_BITS = 6
) (
  input  logic [N_BITS-1:0] lead_i,
  input  logic [N_BITS-2:0] lag_i,
  output logic [N_BITS-1:0] bin_o
);

  // MSB first: the decided upper bit picks which comparator to trust
  always_comb begin
    logic up;
    up = lead_i[N_BITS-1];
    bin_o[N_BITS-1] = up;
    for (int k = N_BITS - 2; k >= 0; k--) begin
      up = up ^ (up ? lag_i[k] : lead_i[k]);
      bin_o[k] = up;
    end
  end

endmodule

// File: rtl/gray_lookback_corrector.sv
module gray_lookback_corrector #(
  parameter int N_BITS    = 6,
  parameter int EXTRA_LSB = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [N_BITS-1:0]             lead_i,
  input  logic [N_BITS-2:0]             lag_i,
  input  logic                          ilv_a_i,
  input  logic                          ilv_b_i,
  output logic [N_BITS+EXTRA_LSB-1:0]   code_o,
  output logic                          valid_o
);

  localparam int LAG_W = N_BITS - 1;
  localparam int IN_W  = N_BITS + LAG_W + 2;
  localparam int OUT_W = N_BITS + EXTRA_LSB;

  logic             s1_valid;
  logic [IN_W-1:0]  s1_data;
  logic [N_BITS-1:0] s1_lead;
  logic [LAG_W-1:0] s1_lag;
  logic             s1_ia, s1_ib;
  logic [N_BITS-1:0] bin;
  logic [OUT_W-1:0] word;

  gec_stage #(.W(IN_W)) u_sample (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i ({lead_i, lag_i, ilv_a_i, ilv_b_i}),
    .valid_o(s1_valid),
    .data_o (s1_data)
  );

  assign {s1_lead, s1_lag, s1_ia, s1_ib} = s1_data;

  gec_resolve #(.N_BITS(N_BITS)) u_resolve (
    .lead_i(s1_lead),
    .lag_i (s1_lag),
    .bin_o (bin)
  );

  generate
    if (EXTRA_LSB != 0) begin : g_fine
      assign word = {bin, s1_ia ^ s1_ib};
    end else begin : g_plain
      assign word = bin;
    end
  endgenerate

  gec_stage #(.W(OUT_W)) u_result (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s1_valid),
    .data_i (word),
    .valid_o(valid_o),
    .data_o (code_o)
  );

endmodule

// File: rtl/gray_lookback_corrector_chk.sv
module gray_lookback_corrector_chk #(
  parameter int N_BITS    = 6,
  parameter int EXTRA_LSB = 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic [N_BITS-1:0]           lead_i,
  input logic [N_BITS-2:0]           lag_i,
  input logic                        ilv_a_i,
  input logic                        ilv_b_i,
  input logic [N_BITS+EXTRA_LSB-1:0] code_o,
  input logic                        valid_o
);
  import gec_pkg::*;

  localparam int OUT_W = N_BITS + EXTRA_LSB;

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (!valid_o && code_o == '0);
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o));

  a_r4_gray_to_bin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lead_i[N_BITS-2:0] == lag_i) |=> ##1
      (code_o[OUT_W-1 -: N_BITS] == N_BITS'(gray_to_bin(32'($past(lead_i, 2))))));

  a_r5_msb_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 (code_o[OUT_W-1] == $past(lead_i[N_BITS-1], 2)));

  generate
    if (EXTRA_LSB != 0) begin : g_fine_chk
      a_r7_fine_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> ##1 (code_o[0] == ($past(ilv_a_i, 2) ^ $past(ilv_b_i, 2))));
    end
  endgenerate

endmodule

bind gray_lookback_corrector gray_lookback_corrector_chk #(
  .N_BITS(N_BITS), .EXTRA_LSB(EXTRA_LSB)
) u_chk (.*);

// File: tb/gray_lookback_corrector_tb.sv
`timescale 1ns/1ps
module gray_lookback_corrector_tb;
  localparam int NB = 6;
  localparam int LW = NB - 1;
  localparam int OW = NB + 1;
  localparam int NV = 1 << NB;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [NB-1:0] lead_i = '0;
  logic [LW-1:0] lag_i = '0;
  logic          ilv_a_i = 1'b0;
  logic          ilv_b_i = 1'b0;
  logic [OW-1:0] code_o;
  logic          valid_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  gray_lookback_corrector #(.N_BITS(NB), .EXTRA_LSB(1)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .lead_i(lead_i), .lag_i(lag_i), .ilv_a_i(ilv_a_i), .ilv_b_i(ilv_b_i),
    .code_o(code_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gray(input int v);
    return v ^ (v >> 1);
  endfunction

  function automatic int upper();
    return int'(code_o[OW-1:1]);
  endfunction

  // drive one sample, return at the falling edge after its result is registered
  task automatic apply(input int ld, input int lg, input bit a, input bit b);
    @(negedge clk_i);
    lead_i = NB'(ld); lag_i = LW'(lg); ilv_a_i = a; ilv_b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    check(valid_o == 1'b1, "R2 valid after two cycles", int'(valid_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid_o in reset", int'(valid_o), 0);
    check(code_o == '0, "R1 code_o in reset", int'(code_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(valid_o == 1'b0 && code_o == '0, "R1 idle after reset", int'(code_o), 0);

    // R4 every Gray code with agreeing comparators
    for (int v = 0; v < NV; v++) begin
      apply(gray(v), gray(v), 1'b0, 1'b0);
      check(upper() == v, "R4 gray to binary", upper(), v);
      check(code_o[0] == 1'b0, "R7 fine bit zero", int'(code_o[0]), 0);
    end

    // R5 R6 adjacent levels, both orders
    for (int u = 0; u < NV - 1; u++) begin
      int j, hi, e;
      j = 0;
      while (((u >> j) & 1) == 1) j++;
      hi = (u >> (j + 1)) & 1;
      e = hi ? u : u + 1;
      apply(gray(u + 1), gray(u), 1'b0, 1'b0);
      check(upper() == e, "R6 lead ahead", upper(), e);
      check(int'(code_o[OW-1]) == ((gray(u + 1) >> (NB - 1)) & 1), "R5 msb from lead",
            int'(code_o[OW-1]), (gray(u + 1) >> (NB - 1)) & 1);
      e = hi ? u + 1 : u;
      apply(gray(u), gray(u + 1), 1'b0, 1'b0);
      check(upper() == e, "R6 lag ahead", upper(), e);
    end

    // R7 interleaved pair
    for (int c = 0; c < 4; c++) begin
      int v;
      v = int'($urandom % NV);
      apply(gray(v), gray(v), c[1], c[0]);
      check(code_o[0] == (c[1] ^ c[0]), "R7 fine bit xor", int'(code_o[0]), c[1] ^ c[0]);
      check(upper() == v, "R7 upper untouched", upper(), v);
    end

    // R3 hold while idle; R2 no result without a sample
    apply(gray(37), gray(37), 1'b1, 1'b0);
    begin
      logic [OW-1:0] held;
      held = code_o;
      for (int i = 0; i < 4; i++) begin
        lead_i = NB'($urandom); lag_i = LW'($urandom);
        ilv_a_i = 1'($urandom); ilv_b_i = 1'($urandom);
        @(negedge clk_i);
        check(valid_o == 1'b0, "R2 no spurious valid", int'(valid_o), 0);
        check(code_o == held, "R3 hold while idle", int'(code_o), int'(held));
      end
    end

    // R9 back-to-back samples
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        check(valid_o == 1'b1, "R9 streaming valid", int'(valid_o), 1);
        check(upper() == i - 2, "R9 streaming order", upper(), i - 2);
      end
      if (i < NV) begin
        lead_i = NB'(gray(i)); lag_i = LW'(gray(i)); valid_i = 1'b1;
      end else begin
        valid_i = 1'b0;
      end
    end
    @(negedge clk_i);

    // R8 quarter-LSB sweep, comparators one LSB apart, random disagreement
    for (int ev = 0; ev < 4; ev++) begin
      int prev;
      prev = 0;
      for (int x = 0; x < 4 * NV; x++) begin
        int va, vb, ld, lg, d, v, r;
        va = (x + 2) / 4; if (va > NV - 1) va = NV - 1;
        vb = (x < 2) ? 0 : (x - 2) / 4;
        ld = gray(va); lg = gray(vb);
        d = (ld ^ lg) & ((1 << LW) - 1);
        if (ev != 0 && d != 0) begin
          if ($urandom % 2 == 1) ld = (ld & ~d) | (lg & d);
          else lg = (lg & ~d) | (ld & d);
        end
        r = int'($urandom % 2);
        apply(ld, lg, 1'((x >> 1) & 1) ^ 1'(r), 1'(r));
        v = x / 4;
        check(upper() >= v - 1 && upper() <= v + 1, "R8 within one LSB", upper(), v);
        check(int'(code_o[0]) == ((x >> 1) & 1), "R7 sweep fine bit", int'(code_o[0]), (x >> 1) & 1);
        if (ev == 0) begin
          check(upper() >= prev, "R8 monotonic", upper(), prev);
          prev = upper();
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule